// File: doc/BRIEF.md
# Low-Power State Protocol Monitor

This block watches the sideband controls that steer a processor through its power-saving states and keeps a copy of the state the processor must be in. Those controls are a stop-clock request, a sleep request, a deep-sleep request, a clock-stop request and a reset. A stop-grant acknowledge input marks entry into the first saving state. The monitor also watches snoop requests and general bus activity. It treats the states as a strict ladder. Stop-Grant is reached only from Normal. Sleep is reached only from Stop-Grant. Deep Sleep is reached only from Sleep. After Deep Sleep ends, a timed PLL-settling interval must pass before the state counts as Sleep again.

Any move that breaks the ladder or the quiet rules of the low-power states sets a sticky flag. A 4-bit code keeps the first violation seen until software or a supervisor pulses the synchronous clear. The settling interval is timed by a prescaler that divides the system clock down to microsecond ticks, and those ticks are brought out for observation. The monitor drives nothing back toward the processor. It is meant to sit beside the control logic as a synthesizable protocol checker.

Top module: `lpm_monitor`

## Requirements
- R1: After reset, `lp_state` is 0 (Normal), `err_flags` is 0 and `err_code` is 0.
- R2: State encoding: 0 Normal, 1 Stop-Grant, 2 Sleep, 3 Deep Sleep, 4 Settling. Normal goes to Stop-Grant when `stop_req` and `stop_ack` are both high. Stop-Grant goes back to Normal when `stop_req` is low and `sleep_req` does not rise. Each transition appears one cycle after the input is sampled.
- R3: A rise of `sleep_req` moves Stop-Grant to Sleep. A rise in any other state sets flag bit 0, gives code 1 and leaves the state unchanged.
- R4: A rise of `deep_req` moves Sleep to Deep Sleep. A rise in any other state sets flag bit 2-1=1, gives code 2 and leaves the state unchanged.
- R5: In Sleep or Settling, a high `bus_act` or a change of `stop_req` sets flag bit 2 (code 3).
- R6: In Deep Sleep, a high `bus_act`, a change of `stop_req` or a change of `sleep_req` sets flag bit 3 (code 4).
- R7: A high `snoop` in Sleep, Deep Sleep or Settling sets flag bit 4 (code 5).
- R8: A fall of `deep_req` moves Deep Sleep to Settling. Settling lasts exactly CLKS_PER_US*SETTLE_US cycles and then becomes Sleep. The prescaler restarts on entry, so `us_tick` pulses every CLKS_PER_US cycles, first in the CLKS_PER_US-th cycle of Settling.
- R9: A fall of `sleep_req` in Sleep moves to Stop-Grant with no error. In Settling it sets flag bit 5 (code 6) and also moves to Stop-Grant.
- R10: In any state, `deep_req` and `clkstop_req` must change in the same cycle. A change of only one of them sets flag bit 6 (code 7).
- R11: While `mon_reset` is high the state is Normal, whatever it was. If `mon_reset` rises in Sleep, Deep Sleep or Settling and `stop_req` or `sleep_req` is still high in the next cycle, flag bit 7 is set (code 8). Ladder and quiet checks R3 to R7 and R9 are suppressed while `mon_reset` is high.
- R12: Flags stay set until `clr_err`. `err_code` holds the first violation; if several occur in one cycle, the lowest code wins. `clr_err` clears flags and code and takes precedence over violations in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of the monitor |
| clr_err | input | 1 | Synchronous clear of flags and code |
| stop_req | input | 1 | Stop-clock request, active high |
| stop_ack | input | 1 | Stop-grant acknowledge |
| sleep_req | input | 1 | Sleep request, active high |
| deep_req | input | 1 | Deep-sleep request, active high |
| clkstop_req | input | 1 | Clock-stop request, must track deep_req |
| mon_reset | input | 1 | Monitored processor reset, active high |
| snoop | input | 1 | Snoop request strobe |
| bus_act | input | 1 | Generic bus-activity strobe |
| lp_state | output | 3 | Tracked state, encoded per R2 |
| us_tick | output | 1 | Microsecond prescaler pulse |
| err_flags | output | 8 | Sticky violation flags, bit n means code n+1 |
| err_code | output | 4 | First violation code, 0 when none |

## Verification
The bench builds the monitor with CLKS_PER_US=4 and SETTLE_US=5. That shortens Settling to 20 cycles, against 6000 at the defaults. With this setting, random walks up and down the ladder finish the settling interval now and then and break it early at other times, so both the timed return to Sleep and the early-wake error are reached often. The short prescaler period also lets a directed pass count every `us_tick` of one full interval.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        LP_NORMAL  = 3'd0,
        LP_STOPGNT = 3'd1,
        LP_SLEEP   = 3'd2,
        LP_DEEP    = 3'd3,
        LP_SETTLE  = 3'd4
    } lp_state_e;

    // sideband vector positions
    localparam int SIG_STOP    = 0;
    localparam int SIG_SLEEP   = 1;
    localparam int SIG_DEEP    = 2;
    localparam int SIG_CLKSTOP = 3;
    localparam int SIG_RST     = 4;
    localparam int NUM_SIG     = 5;

    // violation bit positions; code = position + 1, lowest wins
    localparam int V_SLEEP_SEQ = 0;
    localparam int V_DEEP_SEQ  = 1;
    localparam int V_QUIET     = 2;
    localparam int V_DORMANT   = 3;
    localparam int V_SNOOP     = 4;
    localparam int V_EARLY     = 5;
    localparam int V_PAIR      = 6;
    localparam int V_RSTWARN   = 7;
    localparam int NUM_VIOL    = 8;
    localparam int CODE_W      = 4;

endpackage

// File: rtl/lpm_edges.sv
module lpm_edges #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= sig[i];
        end
        assign rise[i] = sig[i] & ~prev_q[i];
        assign fall[i] = ~sig[i] & prev_q[i];
    end
endmodule

// File: rtl/lpm_settle_timer.sv
module lpm_settle_timer #(
    parameter int CLKS_PER_US = 200,
    parameter int SETTLE_US   = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic us_tick,
    output logic done
);
    localparam int PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam int UW = (SETTLE_US > 1) ? $clog2(SETTLE_US) : 1;

    logic [PW-1:0] pre_q;
    logic [UW-1:0] us_q;

    assign us_tick = (pre_q == PW'(CLKS_PER_US - 1));
    assign done    = run && us_tick && (us_q == UW'(SETTLE_US - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            us_q  <= '0;
        end else if (start) begin
            pre_q <= '0;
            us_q  <= '0;
        end else begin
            pre_q <= us_tick ? '0 : pre_q + 1'b1;
            if (run && us_tick) us_q <= us_q + 1'b1;
        end
    end
endmodule

// File: rtl/lpm_err_log.sv
module lpm_err_log
    import lpm_pkg::*;
#(
    parameter int N = NUM_VIOL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [N-1:0]      viol,
    output logic [N-1:0]      flags,
    output logic [CODE_W-1:0] code
);
    logic [CODE_W-1:0] first_code;

    always_comb begin
        first_code = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (viol[i]) first_code = CODE_W'(i + 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            flags <= '0;
            code  <= '0;
        end else begin
            flags <= flags | viol;
            if (code == '0) code <= first_code;
        end
    end
endmodule

// File: rtl/lpm_monitor.sv
module lpm_monitor
    import lpm_pkg::*;
#(
    parameter int CLKS_PER_US = 200,
    parameter int SETTLE_US   = 30
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_err,
    input  logic                stop_req,
    input  logic                stop_ack,
    input  logic                sleep_req,
    input  logic                deep_req,
    input  logic                clkstop_req,
    input  logic                mon_reset,
    input  logic                snoop,
    input  logic                bus_act,
    output logic [2:0]          lp_state,
    output logic                us_tick,
    output logic [NUM_VIOL-1:0] err_flags,
    output logic [CODE_W-1:0]   err_code
);
    logic [NUM_SIG-1:0]  sig_now, sig_rise, sig_fall, sig_tog;
    logic [NUM_VIOL-1:0] viol;
    lp_state_e           state_q, state_d;
    logic                warn_q, warn_d;
    logic                settle_start, settle_run, settle_done;
    logic                in_quiet, in_dormant, in_lowpow;

    assign sig_now = {mon_reset, clkstop_req, deep_req, sleep_req, stop_req};

    lpm_edges #(.W(NUM_SIG)) u_edges (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (sig_now),
        .rise (sig_rise),
        .fall (sig_fall)
    );
    assign sig_tog = sig_rise | sig_fall;

    assign settle_run   = (state_q == LP_SETTLE);
    assign settle_start = (state_q == LP_DEEP) && (state_d == LP_SETTLE);

    lpm_settle_timer #(.CLKS_PER_US(CLKS_PER_US), .SETTLE_US(SETTLE_US)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (settle_start),
        .run    (settle_run),
        .us_tick(us_tick),
        .done   (settle_done)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        warn_d  = 1'b0;
        if (mon_reset) begin
            state_d = LP_NORMAL;
            warn_d  = sig_rise[SIG_RST] &&
                      (state_q inside {LP_SLEEP, LP_DEEP, LP_SETTLE});
        end else begin
            unique case (state_q)
                LP_NORMAL:  if (stop_req && stop_ack) state_d = LP_STOPGNT;
                LP_STOPGNT: if (sig_rise[SIG_SLEEP])  state_d = LP_SLEEP;
                            else if (!stop_req)       state_d = LP_NORMAL;
                LP_SLEEP:   if (sig_rise[SIG_DEEP])   state_d = LP_DEEP;
                            else if (sig_fall[SIG_SLEEP]) state_d = LP_STOPGNT;
                LP_DEEP:    if (sig_fall[SIG_DEEP])   state_d = LP_SETTLE;
                LP_SETTLE:  if (sig_fall[SIG_SLEEP])  state_d = LP_STOPGNT;
                            else if (settle_done)     state_d = LP_SLEEP;
                default:    state_d = LP_NORMAL;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LP_NORMAL;
            warn_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            warn_q  <= warn_d;
        end
    end

    // violation outputs
    assign in_quiet   = (state_q == LP_SLEEP) || (state_q == LP_SETTLE);
    assign in_dormant = (state_q == LP_DEEP);
    assign in_lowpow  = in_quiet || in_dormant;

    always_comb begin
        viol            = '0;
        viol[V_RSTWARN] = warn_q && (stop_req || sleep_req);
        viol[V_PAIR]    = sig_tog[SIG_DEEP] ^ sig_tog[SIG_CLKSTOP];
        if (!mon_reset) begin
            viol[V_SLEEP_SEQ] = sig_rise[SIG_SLEEP] && (state_q != LP_STOPGNT);
            viol[V_DEEP_SEQ]  = sig_rise[SIG_DEEP] && (state_q != LP_SLEEP);
            viol[V_QUIET]     = in_quiet && (bus_act || sig_tog[SIG_STOP]);
            viol[V_DORMANT]   = in_dormant &&
                                (bus_act || sig_tog[SIG_STOP] || sig_tog[SIG_SLEEP]);
            viol[V_SNOOP]     = in_lowpow && snoop;
            viol[V_EARLY]     = settle_run && sig_fall[SIG_SLEEP];
        end
    end

    lpm_err_log #(.N(NUM_VIOL)) u_log (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr_err),
        .viol (viol),
        .flags(err_flags),
        .code (err_code)
    );

    assign lp_state = state_q;
endmodule

// File: rtl/lpm_monitor_chk.sv
module lpm_monitor_chk
    import lpm_pkg::*;
#(
    parameter int CLKS_PER_US = 200,
    parameter int SETTLE_US   = 30
) (
    input logic                clk,
    input logic                rst_n,
    input logic                clr_err,
    input logic [2:0]          lp_state,
    input logic [NUM_VIOL-1:0] err_flags,
    input logic [CODE_W-1:0]   err_code
);
    localparam int SETTLE_CYC = CLKS_PER_US * SETTLE_US;
    int settle_cyc;

    always_ff @(posedge clk) begin
        if (!rst_n) settle_cyc <= 0;
        else        settle_cyc <= (lp_state == LP_SETTLE) ? settle_cyc + 1 : 0;
    end

    a_r3_sleep_from_ladder: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_state == LP_SLEEP && $past(lp_state) != LP_SLEEP) |->
        ($past(lp_state) == LP_STOPGNT || $past(lp_state) == LP_SETTLE));

    a_r4_deep_from_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_state == LP_DEEP && $past(lp_state) != LP_DEEP) |->
        ($past(lp_state) == LP_SLEEP));

    a_r8_settle_length: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_state == LP_SLEEP && $past(lp_state) == LP_SETTLE) |->
        (settle_cyc == SETTLE_CYC));

    a_r12_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_err |=> (($past(err_flags) & ~err_flags) == '0));

    a_r12_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_err && err_code != '0) |=> (err_code == $past(err_code)));

    a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_err |=> (err_code == '0 && err_flags == '0));

    a_r12_code_flag_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code == '0) == (err_flags == '0));

    a_r12_code_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != '0) |-> (((err_flags >> (err_code - 4'd1)) & 8'd1) != 8'd0));
endmodule

bind lpm_monitor lpm_monitor_chk #(
    .CLKS_PER_US(CLKS_PER_US),
    .SETTLE_US  (SETTLE_US)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_err  (clr_err),
    .lp_state (lp_state),
    .err_flags(err_flags),
    .err_code (err_code)
);

// File: tb/tb_lpm_monitor.sv
`timescale 1ns/1ps
module tb_lpm_monitor;
    localparam int C  = 4;
    localparam int S  = 5;
    localparam int CS = C * S;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_err = 0, stop_req = 0, stop_ack = 0, sleep_req = 0, deep_req = 0;
    logic clkstop_req = 0, mon_reset = 0, snoop = 0, bus_act = 0;
    logic [2:0] lp_state;
    logic       us_tick;
    logic [7:0] err_flags;
    logic [3:0] err_code;

    int checks = 0, errors = 0;
    bit done = 0;

    // reference model state
    int         m_state = 0, m_cnt = 0;
    logic [7:0] m_flags = 0;
    logic [3:0] m_code = 0;
    bit m_warn = 0;
    bit p_stop = 0, p_sleep = 0, p_deep = 0, p_clk = 0, p_rst = 0;

    always #2.5 clk = ~clk;

    lpm_monitor #(.CLKS_PER_US(C), .SETTLE_US(S)) dut (
        .clk(clk), .rst_n(rst_n), .clr_err(clr_err), .stop_req(stop_req),
        .stop_ack(stop_ack), .sleep_req(sleep_req), .deep_req(deep_req),
        .clkstop_req(clkstop_req), .mon_reset(mon_reset), .snoop(snoop),
        .bus_act(bus_act), .lp_state(lp_state), .us_tick(us_tick),
        .err_flags(err_flags), .err_code(err_code)
    );

    function automatic logic [3:0] lowest_code(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return 4'(i + 1);
        return 4'd0;
    endfunction

    task automatic model_step();
        logic [7:0] v = 0;
        int ns = m_state;
        bit nw = 0;
        bit t_stop = stop_req != p_stop, t_sl = sleep_req != p_sleep;
        bit t_d = deep_req != p_deep, t_c = clkstop_req != p_clk;
        bit r_sl = sleep_req && !p_sleep, f_sl = !sleep_req && p_sleep;
        bit r_d = deep_req && !p_deep, f_d = !deep_req && p_deep;
        if (m_warn && (stop_req || sleep_req)) v[7] = 1;
        if (t_d != t_c) v[6] = 1;
        if (mon_reset) begin
            ns = 0;
            nw = !p_rst && (m_state >= 2);
        end else begin
            if (r_sl && m_state != 1) v[0] = 1;
            if (r_d && m_state != 2) v[1] = 1;
            if ((m_state == 2 || m_state == 4) && (bus_act || t_stop)) v[2] = 1;
            if (m_state == 3 && (bus_act || t_stop || t_sl)) v[3] = 1;
            if (m_state >= 2 && snoop) v[4] = 1;
            case (m_state)
                0: if (stop_req && stop_ack) ns = 1;
                1: if (r_sl) ns = 2; else if (!stop_req) ns = 0;
                2: if (r_d) ns = 3; else if (f_sl) ns = 1;
                3: if (f_d) ns = 4;
                4: if (f_sl) begin v[5] = 1; ns = 1; end
                   else if (m_cnt + 1 == CS) ns = 2;
                default: ns = 0;
            endcase
        end
        m_cnt = (m_state == 4) ? m_cnt + 1 : 0;
        if (clr_err) begin
            m_flags = 0; m_code = 0;
        end else begin
            if (m_code == 0) m_code = lowest_code(v);
            m_flags = m_flags | v;
        end
        m_state = ns; m_warn = nw;
        p_stop = stop_req; p_sleep = sleep_req; p_deep = deep_req;
        p_clk = clkstop_req; p_rst = mon_reset;
    endtask

    task automatic step(string tag);
        model_step();
        @(posedge clk);
        #1;
        checks++;
        if (lp_state != 3'(m_state) || err_flags != m_flags || err_code != m_code) begin
            errors++;
            $display("FAIL %s: state/flags/code actual %0d/%h/%0d expected %0d/%h/%0d",
                     tag, lp_state, err_flags, err_code, m_state, m_flags, m_code);
        end
    endtask

    task automatic expect_out(string tag, int st, int code);
        checks++;
        if (lp_state != 3'(st) || err_code != 4'(code)) begin
            errors++;
            $display("FAIL %s: state/code actual %0d/%0d expected %0d/%0d",
                     tag, lp_state, err_code, st, code);
        end
    endtask

    task automatic clear(string tag);
        clr_err = 1; step(tag); clr_err = 0;
    endtask

    task automatic to_sleep(string tag);
        stop_req = 1; stop_ack = 1; step(tag);
        stop_ack = 0; sleep_req = 1; step(tag);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            summary();
            $finish;
        end
    end

    initial begin
        int n, ticks;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        expect_out("R1", 0, 0);
        checks++;
        if (err_flags != 0) begin
            errors++; $display("FAIL R1: flags actual %h expected 00", err_flags);
        end

        // R2 ladder entry needs the acknowledge
        stop_req = 1; step("R2"); expect_out("R2", 0, 0);
        stop_ack = 1; step("R2"); expect_out("R2", 1, 0);
        stop_ack = 0; sleep_req = 1; step("R3"); expect_out("R3", 2, 0);
        deep_req = 1; clkstop_req = 1; step("R4"); expect_out("R4", 3, 0);
        bus_act = 1; step("R6"); bus_act = 0; expect_out("R6", 3, 4);
        clear("R12");
        // R8 timed settle back to Sleep
        deep_req = 0; clkstop_req = 0; step("R8"); expect_out("R8", 4, 0);
        n = 0; ticks = 0;
        while (lp_state == 3'd4 && n < 100) begin
            if (us_tick) ticks++;
            step("R8"); n++;
        end
        checks++;
        if (n != CS || ticks != S) begin
            errors++;
            $display("FAIL R8: cycles/ticks actual %0d/%0d expected %0d/%0d", n, ticks, CS, S);
        end
        expect_out("R8", 2, 0);
        sleep_req = 0; step("R9"); expect_out("R9", 1, 0);
        stop_req = 0; step("R2"); expect_out("R2", 0, 0);
        // R3 / R4 out-of-ladder requests
        sleep_req = 1; step("R3"); expect_out("R3", 0, 1);
        sleep_req = 0; step("R3"); clear("R12");
        deep_req = 1; clkstop_req = 1; step("R4"); expect_out("R4", 0, 2);
        deep_req = 0; clkstop_req = 0; step("R4"); clear("R12");
        // R10 pair mismatch
        clkstop_req = 1; step("R10"); expect_out("R10", 0, 7);
        clkstop_req = 0; step("R10"); clear("R12");
        // R5 and R7 in Sleep
        to_sleep("R5");
        bus_act = 1; step("R5"); bus_act = 0; expect_out("R5", 2, 3);
        snoop = 1; step("R7"); snoop = 0; expect_out("R7", 2, 3);
        checks++;
        if (err_flags != 8'h14) begin
            errors++; $display("FAIL R7: flags actual %h expected 14", err_flags);
        end
        clear("R12");
        // R9 early wake during settling
        deep_req = 1; clkstop_req = 1; step("R4");
        deep_req = 0; clkstop_req = 0; step("R8");
        repeat (3) step("R8");
        sleep_req = 0; step("R9"); expect_out("R9", 1, 6);
        clear("R12");
        // R11 reset from Sleep, requests left high
        sleep_req = 1; step("R11");
        mon_reset = 1; step("R11"); expect_out("R11", 0, 0);
        step("R11"); expect_out("R11", 0, 8);
        mon_reset = 0; sleep_req = 0; stop_req = 0; step("R11"); clear("R12");
        // R11 reset from Sleep, requests dropped at once
        to_sleep("R11");
        mon_reset = 1; step("R11");
        sleep_req = 0; stop_req = 0; step("R11"); expect_out("R11", 0, 0);
        mon_reset = 0; step("R11");
        // R12 simultaneous violations, first code held, clear wins
        deep_req = 1; sleep_req = 1; step("R12"); expect_out("R12", 0, 1);
        clkstop_req = 1; step("R12"); expect_out("R12", 0, 1);
        clr_err = 1; clkstop_req = 0; step("R12"); clr_err = 0;
        expect_out("R12", 0, 0);
        deep_req = 0; sleep_req = 0; step("R12"); clear("R12");

        // constrained random walk
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 7) == 0) stop_req = ~stop_req;
            stop_ack = ($urandom_range(0, 1) == 1);
            if ($urandom_range(0, 9) == 0) sleep_req = ~sleep_req;
            if ($urandom_range(0, 11) == 0) begin
                deep_req = ~deep_req;
                if ($urandom_range(0, 15) != 0) clkstop_req = deep_req;
            end else if ($urandom_range(0, 63) == 0) clkstop_req = ~clkstop_req;
            bus_act   = ($urandom_range(0, 23) == 0);
            snoop     = ($urandom_range(0, 31) == 0);
            mon_reset = mon_reset ? ($urandom_range(0, 2) == 0) : ($urandom_range(0, 79) == 0);
            clr_err   = ($urandom_range(0, 39) == 0);
            step("R2,R3,R4,R5,R6,R7,R8,R9,R10,R11,R12 random");
        end
        done = 1;
        summary();
        $finish;
    end
endmodule